// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge

This block arbitrates interrupt service among a chain of request sources. Each source sits in a cell, and a cell's place in the chain sets its priority. Cell 0 is the highest. All pending requests are ORed into one shared interrupt line. The processor-side controller answers that line with an acknowledge signal. The acknowledge enters cell 0 and moves down the chain through each cell that has no interest in it. The first cell that held a request when the acknowledge arrived keeps the acknowledge from travelling further. That cell then drives its identifier onto a shared bus.

A request that arrives at a cell while the acknowledge is already present at that cell does not win the grant. Instead, it blocks the acknowledge from reaching the cells below. This removes the grant from any lower cell that is being serviced. The processor later drops the acknowledge, after a service-done pulse or after the interrupt line goes low. It waits one or more cycles, then acknowledges again, and the earlier cell wins. The bus drive of each cell is modelled as an enable. A one-hot merge of the identifiers forms the bus value.

Top module: `irq_daisy_chain`

## Requirements
- R1: `irq_o` is the OR of all bits of `req_i`, with no clock delay.
- R2: While the controller is idle, sampling `irq_o` high at a rising clock edge raises `iack_o` in the cycle that follows.
- R3: One cycle after `iack_o` rises, the bus enable goes to the lowest-index cell whose request was high at the acknowledge edge. `bus_o` then reads that cell's index plus 1.
- R4: A cell with neither a pending request nor a grant passes the acknowledge down the chain. A cell that holds the grant stops it. No cell below the granted cell gets an enable, and `iack_tail_o` stays 0.
- R5: At most one bit of `bus_en_o` is ever 1. `bus_o` is 0 when no bit is set.
- R6: A request that rises while its cell's acknowledge input is already high takes no grant. It blocks the acknowledge for all lower cells, which clears any lower grant in the same cycle.
- R7: While `iack_o` is 0, `bus_en_o` is all zero and `bus_o` is 0.
- R8: A `done_i` pulse sampled while `iack_o` is high makes `iack_o` 0 in the next cycle.
- R9: `irq_o` sampled low at a clock edge while `iack_o` is high makes `iack_o` 0 in the next cycle.
- R10: After `iack_o` falls, it stays 0 for at least two cycles. With `irq_o` still high, it rises again in the third cycle after the fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_DEV | Per-cell interrupt request; bit 0 is highest priority |
| done_i | input | 1 | Service-done pulse from the processor |
| irq_o | output | 1 | Shared interrupt line |
| iack_o | output | 1 | Acknowledge into the head of the chain |
| iack_tail_o | output | 1 | Acknowledge leaving the last cell |
| bus_en_o | output | N_DEV | Per-cell bus drive enables |
| bus_o | output | ID_W | Shared bus carrying the granted cell's index plus 1 |

## Verification
The bench builds the block with four cells and three-bit identifiers. Four cells are enough to place a grant at the top, in the middle and at the bottom of the chain. They also leave requesting cells both above and below a granted cell. This lets mixed request patterns, preemption of a middle cell by the head cell, and re-acknowledge of a lower cell after the head cell finishes all be checked against a priority model kept in the bench.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  typedef enum logic [1:0] {
    ACK_IDLE = 2'd0,
    ACK_HOLD = 2'd1,
    ACK_GAP  = 2'd2
  } ack_state_e;
endpackage

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_chain_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic done_i,
  output logic iack_o
);
  ack_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ACK_IDLE: if (irq_i) state_d = ACK_HOLD;
      ACK_HOLD: if (done_i || !irq_i) state_d = ACK_GAP;
      ACK_GAP:  state_d = ACK_IDLE;
      default:  state_d = ACK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ACK_IDLE;
    else         state_q <= state_d;
  end

  assign iack_o = (state_q == ACK_HOLD);
endmodule

// File: rtl/irq_chain_cell.sv
module irq_chain_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic iack_in_i,
  output logic iack_out_o,
  output logic bus_en_o
);
  logic iack_in_q, claim_q;

  // request is sampled only on the acknowledge rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iack_in_q <= 1'b0;
      claim_q   <= 1'b0;
    end else begin
      iack_in_q <= iack_in_i;
      if (!iack_in_i)      claim_q <= 1'b0;
      else if (!iack_in_q) claim_q <= req_i;
    end
  end

  // a pending request blocks downstream even without a claim (preemption)
  assign iack_out_o = iack_in_i & ~req_i & ~claim_q;
  assign bus_en_o   = iack_in_i & claim_q;
endmodule

// File: rtl/irq_bus_mux.sv
module irq_bus_mux #(
  parameter int N_DEV = 4,
  parameter int ID_W  = 3
) (
  input  logic [N_DEV-1:0] en_i,
  output logic [ID_W-1:0]  bus_o
);
  always_comb begin
    bus_o = '0;
    for (int i = 0; i < N_DEV; i++) begin
      if (en_i[i]) bus_o = bus_o | ID_W'(i + 1);
    end
  end
endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain #(
  parameter int N_DEV = 4,
  parameter int ID_W  = $clog2(N_DEV + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DEV-1:0] req_i,
  input  logic             done_i,
  output logic             irq_o,
  output logic             iack_o,
  output logic             iack_tail_o,
  output logic [N_DEV-1:0] bus_en_o,
  output logic [ID_W-1:0]  bus_o
);
  logic [N_DEV:0] chain;

  assign irq_o    = |req_i;
  assign chain[0] = iack_o;

  irq_ack_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_o),
    .done_i (done_i),
    .iack_o (iack_o)
  );

  for (genvar g = 0; g < N_DEV; g++) begin : g_cell
    irq_chain_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (req_i[g]),
      .iack_in_i  (chain[g]),
      .iack_out_o (chain[g+1]),
      .bus_en_o   (bus_en_o[g])
    );
  end

  assign iack_tail_o = chain[N_DEV];

  irq_bus_mux #(.N_DEV(N_DEV), .ID_W(ID_W)) u_mux (
    .en_i  (bus_en_o),
    .bus_o (bus_o)
  );
endmodule

// File: rtl/irq_daisy_chain_chk.sv
module irq_daisy_chain_chk #(
  parameter int N_DEV = 4,
  parameter int ID_W  = $clog2(N_DEV + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_DEV-1:0] req_i,
  input logic             done_i,
  input logic             irq_o,
  input logic             iack_o,
  input logic             iack_tail_o,
  input logic [N_DEV-1:0] bus_en_o,
  input logic [ID_W-1:0]  bus_o
);
  AST_BUS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bus_en_o)); // R5

  AST_ACK_FOLLOWS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iack_o) |-> $past(irq_o)); // R2

  AST_NO_ACK_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iack_o |-> (bus_en_o == '0 && bus_o == '0)); // R7

  AST_DONE_DROPS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_o && done_i) |=> !iack_o); // R8

  AST_IRQ_LOW_DROPS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_o && !irq_o) |=> !iack_o); // R9

  AST_ACK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(iack_o) |=> !iack_o); // R10

  AST_TAIL_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_o != '0) |-> !iack_tail_o); // R4

  for (genvar g = 0; g < N_DEV; g++) begin : g_req
    AST_GRANT_HAD_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(bus_en_o[g]) |-> $past(req_i[g])); // R3
  end
endmodule

bind irq_daisy_chain irq_daisy_chain_chk #(.N_DEV(N_DEV)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .done_i      (done_i),
  .irq_o       (irq_o),
  .iack_o      (iack_o),
  .iack_tail_o (iack_tail_o),
  .bus_en_o    (bus_en_o),
  .bus_o       (bus_o)
);

// File: tb/irq_daisy_chain_tb.sv
module irq_daisy_chain_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_DEV = 4;
  localparam int ID_W  = 3;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N_DEV-1:0] req = '0;
  logic             done = 1'b0;
  logic             irq, iack, tail;
  logic [N_DEV-1:0] bus_en;
  logic [ID_W-1:0]  bus;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_daisy_chain #(.N_DEV(N_DEV), .ID_W(ID_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .done_i(done),
    .irq_o(irq), .iack_o(iack), .iack_tail_o(tail),
    .bus_en_o(bus_en), .bus_o(bus)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  function automatic int winner(input logic [N_DEV-1:0] r);
    for (int i = 0; i < N_DEV; i++) if (r[i]) return i;
    return -1;
  endfunction

  // finish service of the granted cell: clear its request, pulse done
  task automatic finish(input int idx);
    req[idx] = 1'b0;
    done = 1'b1;
    step(1);
    done = 1'b0;
    chk("R8 iack drops after done", iack, 0);
    chk("R7 no enable without iack", bus_en, 0);
    chk("R7 bus idle without iack", bus, 0);
  endtask

  task automatic t_reset();
    chk("R1 irq idle", irq, 0);
    chk("R7 iack reset", iack, 0);
    chk("R5 bus reset", bus, 0);
    chk("R4 tail reset", tail, 0);
  endtask

  task automatic t_grant(input logic [N_DEV-1:0] pat);
    int w;
    w = winner(pat);
    req = pat;
    #1;
    chk("R1 irq follows req", irq, 1);
    step(1);
    chk("R2 iack raised", iack, 1);
    chk("R3 no enable on ack edge", bus_en, 0);
    step(1);
    chk("R3 enable of winner", bus_en, 1 << w);
    chk("R3 bus id", bus, w + 1);
    chk("R4 tail blocked", tail, 0);
    req = '0;
    req[w] = 1'b1;
    finish(w);
    step(2);
    chk("R2 stays idle without irq", iack, 0);
  endtask

  task automatic t_irq_drop();
    req = 4'b0010;
    step(2);
    chk("R3 cell1 granted", bus, 2);
    req = '0;
    step(1);
    chk("R9 iack drops on irq low", iack, 0);
    chk("R7 bus released", bus, 0);
    step(2);
  endtask

  task automatic t_regrant();
    req = 4'b0011;
    step(2);
    chk("R3 cell0 first", bus, 1);
    req[0] = 1'b0;
    done = 1'b1;
    step(1);
    done = 1'b0;
    chk("R8 drop", iack, 0);
    step(1);
    chk("R10 gap held", iack, 0);
    step(1);
    chk("R10 re-ack", iack, 1);
    step(1);
    chk("R10 cell1 regranted", bus, 2);
    finish(1);
    step(2);
  endtask

  task automatic t_preempt();
    req = 4'b0100;
    step(2);
    chk("R3 cell2 granted", bus, 3);
    req[0] = 1'b1;
    #1;
    chk("R6 lower grant cleared", bus_en, 0);
    step(1);
    chk("R6 late request gets no grant", bus_en, 0);
    chk("R6 iack still held", iack, 1);
    req[2] = 1'b0;
    done = 1'b1;
    step(1);
    done = 1'b0;
    chk("R8 iack drops", iack, 0);
    step(1);
    chk("R10 gap", iack, 0);
    step(1);
    chk("R10 re-ack for head", iack, 1);
    step(1);
    chk("R6 head granted", bus_en, 1);
    chk("R6 head id", bus, 1);
    finish(0);
    step(2);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_err++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    step(2);
    rst_ni = 1'b1;
    step(1);
    t_reset();
    t_grant(4'b0001);
    t_grant(4'b1000);
    t_grant(4'b1010);
    t_grant(4'b1100);
    t_grant(4'b0110);
    t_grant(4'b1111);
    t_irq_drop();
    t_regrant();
    t_preempt();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule